// File: doc/BRIEF.md
# Code Patch Comparator Remap Unit

This block sits beside the instruction and literal fetch path of a processor and compares each access address in the low code region with a set of programmable comparators. When an enabled comparator matches, the block does one of two things. It can redirect the access to one word of an aligned table in system space, so that patched code or constants are read from there. Or it can raise a breakpoint flag on the lower halfword, the upper halfword or both halfwords of the fetched word, and leave the address unchanged.

The first block of comparators sees instruction fetches only. The last ones see literal data loads only, and they always remap. Matching is combinational, so the outputs are valid in the same cycle as the access strobe. A word-addressed register port holds the global control word, the remap table base and one word per comparator. The same port returns fixed identification words at the top of the 4 KB window.

Top module: `code_patch_unit`

## Requirements
- R1: After reset the global enable and every comparator enable are 0. No access matches, and the control word reads 0x0000_0260.
- R2: A write to the control word (word offset 0) changes its enable bit 0 only when write-data bit 1 (the key) is 1. Bit 1 always reads 0, and bits 31:15 read 0 whatever was written.
- R3: The control word reads bits 14:12 as NUM_CODE/16, bits 11:8 as NUM_LIT and bits 7:4 as NUM_CODE%16. With the defaults this is 0, 2 and 6.
- R4: The remap word (word offset 1) stores bits 28:5. It reads bits 31:29 as 3'b001 and bits 4:0 as 0.
- R5: Comparator word k sits at word offset 2+k. Its action field is in bits 31:30, its compare address in bits 28:2 and its enable in bit 0. Bits 29 and 1 read 0.
- R6: A comparator matches only when all of these hold: the access valid strobe is 1, the global enable and its own enable are both 1, access address bits 31:29 are 000, and access bits 28:2 equal its compare address.
- R7: Comparators 0 to NUM_CODE-1 match only instruction fetches (acc_is_lit=0). The remaining comparators match only literal loads (acc_is_lit=1).
- R8: A remapping match drives out_addr = {3'b001, remap bits 28:5, winning index[2:0], acc_addr[1:0]} and sets out_remap.
- R9: On an instruction comparator the action field selects the result. 00 remaps. 01 sets out_bkpt_lo. 10 sets out_bkpt_hi. 11 sets both flags. A breakpoint leaves out_addr equal to acc_addr and out_remap at 0.
- R10: A literal comparator treats any action value as 00 and always remaps.
- R11: When several comparators match the same access, the lowest-numbered one supplies both the index and the action.
- R12: Word offsets 0x3F4 to 0x3FF read the fixed identification bytes 04,00,00,00,03,B0,0B,00,0D,E0,05,B1, in that order, zero-extended to 32 bits. Other unmapped offsets read 0.
- R13: A register write is seen by matching only from the clock edge that captures it. An access in the same cycle uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access address strobe |
| acc_addr | input | 32 | Access byte address |
| acc_is_lit | input | 1 | 1 = literal data load, 0 = instruction fetch |
| out_addr | output | 32 | Remapped or unchanged address |
| out_remap | output | 1 | Access was remapped |
| out_bkpt_lo | output | 1 | Breakpoint on lower halfword |
| out_bkpt_hi | output | 1 | Breakpoint on upper halfword |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register word offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The bench builds the block with the default parameters: six instruction comparators and two literal comparators. This gives a three-bit index that fills the remap address exactly. It also puts both comparator kinds and the boundary between them, index 5 against index 6, within reach of both the directed and the random stimulus. The random accesses draw from a small pool of addresses, so several comparators often hold the same address. That makes the lowest-index priority, and the forced remap of the literal comparators, happen often.

// File: rtl/cpatch_pkg.sv
package cpatch_pkg;

    localparam int ADDR_W = 32;
    localparam int RA_W   = 10;

    localparam logic [RA_W-1:0] OFF_CTRL  = 10'h000;
    localparam logic [RA_W-1:0] OFF_REMAP = 10'h001;
    localparam logic [RA_W-1:0] OFF_CMP0  = 10'h002;
    localparam logic [RA_W-1:0] OFF_ID0   = 10'h3F4;
    localparam int              ID_WORDS  = 12;

    // action selected by a comparator when it wins
    typedef enum logic [1:0] {
        ACT_REMAP   = 2'b00,
        ACT_BK_LO   = 2'b01,
        ACT_BK_HI   = 2'b10,
        ACT_BK_BOTH = 2'b11
    } act_e;

    typedef struct packed {
        act_e        act;
        logic [26:0] cmp;   // address bits 28:2
        logic        en;
    } cmp_reg_t;

    function automatic logic [7:0] id_byte(input logic [3:0] k);
        case (k)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h03;
            4'd5:    id_byte = 8'hB0;
            4'd6:    id_byte = 8'h0B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hE0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cpatch_regs.sv
module cpatch_regs
    import cpatch_pkg::*;
#(
    parameter int NUM_CODE = 6,
    parameter int NUM_LIT  = 2,
    parameter int NUM_CMP  = NUM_CODE + NUM_LIT,
    parameter int BASE_W   = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wen,
    input  logic [RA_W-1:0]      reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 glob_en,
    output logic [BASE_W-1:0]    remap_base,
    output cmp_reg_t             cmps [NUM_CMP]
);
    localparam int BASE_LO = 29 - BASE_W;

    localparam logic [2:0] BANKS  = 3'(NUM_CODE / 16);
    localparam logic [3:0] CODE_N = 4'(NUM_CODE % 16);
    localparam logic [3:0] LIT_N  = 4'(NUM_LIT);

    logic unused_bits;
    assign unused_bits = reg_wdata[29];

    always_ff @(posedge clk) begin
        if (rst)
            glob_en <= 1'b0;
        else if (reg_wen && reg_addr == OFF_CTRL && reg_wdata[1])
            glob_en <= reg_wdata[0];
    end

    // remap base has no reset value
    always_ff @(posedge clk) begin
        if (reg_wen && reg_addr == OFF_REMAP)
            remap_base <= reg_wdata[28:BASE_LO];
    end

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam logic [RA_W-1:0] MY_OFF = RA_W'(OFF_CMP0 + g);
        always_ff @(posedge clk) begin
            if (rst)
                cmps[g] <= '0;
            else if (reg_wen && reg_addr == MY_OFF)
                cmps[g] <= '{act: act_e'(reg_wdata[31:30]),
                             cmp: reg_wdata[28:2],
                             en:  reg_wdata[0]};
        end
    end

    logic [RA_W-1:0] id_rel;
    assign id_rel = reg_addr - OFF_ID0;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_CTRL)
            reg_rdata = {17'b0, BANKS, LIT_N, CODE_N, 3'b000, glob_en};
        else if (reg_addr == OFF_REMAP)
            reg_rdata = {3'b001, remap_base, BASE_LO'(0)};
        else if (reg_addr >= OFF_ID0 && id_rel < RA_W'(ID_WORDS))
            reg_rdata = {24'b0, id_byte(id_rel[3:0])};
        for (int i = 0; i < NUM_CMP; i++)
            if (reg_addr == RA_W'(OFF_CMP0 + i))
                reg_rdata = {cmps[i].act, 1'b0, cmps[i].cmp, 1'b0, cmps[i].en};
    end

    // R2
    key_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == OFF_CTRL && !reg_wdata[1]) |=> $stable(glob_en));

    // R2
    ctrl_key_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFF_CTRL) |-> (reg_rdata[1] == 1'b0 && reg_rdata[31:15] == '0));

endmodule

// File: rtl/cpatch_match.sv
module cpatch_match
    import cpatch_pkg::*;
#(
    parameter int NUM_CODE = 6,
    parameter int NUM_LIT  = 2,
    parameter int NUM_CMP  = NUM_CODE + NUM_LIT,
    parameter int IDX_W    = 3,
    parameter int BASE_W   = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic                 acc_is_lit,
    input  logic                 glob_en,
    input  logic [BASE_W-1:0]    remap_base,
    input  cmp_reg_t             cmps [NUM_CMP],
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_remap,
    output logic                 out_bkpt_lo,
    output logic                 out_bkpt_hi
);
    logic [NUM_CMP-1:0] hit;
    act_e               eff [NUM_CMP];
    logic               code_region;

    assign code_region = (acc_addr[31:29] == 3'b000);

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        localparam bit IS_LIT = (g >= NUM_CODE);
        assign hit[g] = acc_valid && glob_en && cmps[g].en && code_region
                      && (acc_is_lit == IS_LIT)
                      && (acc_addr[28:2] == cmps[g].cmp);
        if (IS_LIT) begin : g_lit
            assign eff[g] = ACT_REMAP;
        end else begin : g_code
            assign eff[g] = cmps[g].act;
        end
    end

    logic             win;
    logic [IDX_W-1:0] widx;
    act_e             wact;

    always_comb begin
        win  = 1'b0;
        widx = '0;
        wact = ACT_REMAP;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win  = 1'b1;
                widx = IDX_W'(i);
                wact = eff[i];
            end
        end
    end

    always_comb begin
        out_addr    = acc_addr;
        out_remap   = 1'b0;
        out_bkpt_lo = 1'b0;
        out_bkpt_hi = 1'b0;
        if (win) begin
            if (wact == ACT_REMAP) begin
                out_remap = 1'b1;
                out_addr  = {3'b001, remap_base, widx, acc_addr[1:0]};
            end else begin
                out_bkpt_lo = wact[0];
                out_bkpt_hi = wact[1];
            end
        end
    end

    // R9
    remap_vs_bkpt_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_remap && (out_bkpt_lo || out_bkpt_hi)));

    // R9
    bkpt_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (out_bkpt_lo || out_bkpt_hi) |-> (out_addr == acc_addr));

    // R8
    remap_shape_chk: assert property (@(posedge clk) disable iff (rst)
        out_remap |-> (out_addr[31:29] == 3'b001 && out_addr[1:0] == acc_addr[1:0]));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid || !glob_en || !code_region)
            |-> (!out_remap && !out_bkpt_lo && !out_bkpt_hi && out_addr == acc_addr));

    // R10
    lit_no_bkpt_chk: assert property (@(posedge clk) disable iff (rst)
        acc_is_lit |-> (!out_bkpt_lo && !out_bkpt_hi));

    // R11
    one_winner_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |-> (out_remap || out_bkpt_lo || out_bkpt_hi));

endmodule

// File: rtl/code_patch_unit.sv
module code_patch_unit
    import cpatch_pkg::*;
#(
    parameter int NUM_CODE = 6,
    parameter int NUM_LIT  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_is_lit,
    output logic [31:0]       out_addr,
    output logic              out_remap,
    output logic              out_bkpt_lo,
    output logic              out_bkpt_hi,
    input  logic              reg_wen,
    input  logic [9:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    localparam int NUM_CMP = NUM_CODE + NUM_LIT;
    localparam int IDX_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;
    localparam int BASE_W  = 27 - IDX_W;

    logic              glob_en;
    logic [BASE_W-1:0] remap_base;
    cmp_reg_t          cmps [NUM_CMP];

    cpatch_regs #(
        .NUM_CODE (NUM_CODE),
        .NUM_LIT  (NUM_LIT),
        .NUM_CMP  (NUM_CMP),
        .BASE_W   (BASE_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .glob_en    (glob_en),
        .remap_base (remap_base),
        .cmps       (cmps)
    );

    cpatch_match #(
        .NUM_CODE (NUM_CODE),
        .NUM_LIT  (NUM_LIT),
        .NUM_CMP  (NUM_CMP),
        .IDX_W    (IDX_W),
        .BASE_W   (BASE_W)
    ) u_match (
        .clk         (clk),
        .rst         (rst),
        .acc_valid   (acc_valid),
        .acc_addr    (acc_addr),
        .acc_is_lit  (acc_is_lit),
        .glob_en     (glob_en),
        .remap_base  (remap_base),
        .cmps        (cmps),
        .out_addr    (out_addr),
        .out_remap   (out_remap),
        .out_bkpt_lo (out_bkpt_lo),
        .out_bkpt_hi (out_bkpt_hi)
    );

endmodule

// File: tb/code_patch_unit_bench.sv
module code_patch_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic        acc_is_lit;
    logic [31:0] out_addr;
    logic        out_remap, out_bkpt_lo, out_bkpt_hi;
    logic        reg_wen;
    logic [9:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    code_patch_unit u_code_patch_unit (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_is_lit(acc_is_lit),
        .out_addr(out_addr), .out_remap(out_remap),
        .out_bkpt_lo(out_bkpt_lo), .out_bkpt_hi(out_bkpt_hi),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // bench model of the register state
    logic        m_en;
    logic [23:0] m_base;
    logic [1:0]  m_act [8];
    logic [26:0] m_cmp [8];
    logic        m_cen [8];

    function automatic logic [34:0] expect_out(input logic [31:0] a, input logic lit,
                                               input logic v);
        logic [31:0] ea = a;
        logic er = 0, el = 0, eh = 0, found = 0;
        logic [1:0] act;
        if (v && m_en && a[31:29] == 3'b000) begin
            for (int i = 0; i < 8; i++) begin
                if (!found && m_cen[i] && m_cmp[i] == a[28:2] && (lit == (i >= 6))) begin
                    found = 1;
                    act = (i >= 6) ? 2'b00 : m_act[i];
                    if (act == 2'b00) begin
                        er = 1;
                        ea = {3'b001, m_base, 3'(i), a[1:0]};
                    end else begin
                        el = act[0];
                        eh = act[1];
                    end
                end
            end
        end
        return {er, el, eh, ea};
    endfunction

    function automatic logic [31:0] id_exp(input int k);
        case (k)
            0: return 32'h04;  4: return 32'h03;  5: return 32'hB0;  6: return 32'h0B;
            8: return 32'h0D;  9: return 32'hE0; 10: return 32'h05; 11: return 32'hB1;
            default: return 32'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_wr(input logic [9:0] a, input logic [31:0] d);
        if (a == 10'd0 && d[1]) m_en = d[0];
        else if (a == 10'd1) m_base = d[28:5];
        else if (a >= 10'd2 && a <= 10'd9) begin
            m_act[a-2] = d[31:30];
            m_cmp[a-2] = d[28:2];
            m_cen[a-2] = d[0];
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 0;
        model_wr(a, d);
    endtask

    task automatic rd(input string tag, input logic [9:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, {32'b0, reg_rdata}, {32'b0, exp});
    endtask

    task automatic acc(input string tag, input logic [31:0] a, input logic lit,
                       input logic v);
        logic [34:0] e;
        @(negedge clk);
        acc_valid = v; acc_addr = a; acc_is_lit = lit;
        #1;
        e = expect_out(a, lit, v);
        chk(tag, {29'b0, out_remap, out_bkpt_lo, out_bkpt_hi, out_addr}, {29'b0, e});
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [26:0] pool [4];
        logic [34:0] e;
        pool[0] = 27'h40; pool[1] = 27'h41; pool[2] = 27'h80; pool[3] = 27'h7F;
        m_en = 0; m_base = '0;
        for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_cmp[i] = 0; m_cen[i] = 0; end
        acc_valid = 0; acc_addr = 0; acc_is_lit = 0;
        reg_wen = 0; reg_addr = 0; reg_wdata = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 R3 reset state and fixed fields
        rd("R1 R3 ctrl after reset", 10'd0, 32'h0000_0260);
        for (int k = 0; k < 8; k++) rd("R1 cmp cleared", 10'(2 + k), 32'h0);
        acc("R1 no match after reset", 32'h0000_0100, 0, 1);

        // R2 key gating
        wr(10'd0, 32'h0000_0001);
        rd("R2 keyless write ignored", 10'd0, 32'h0000_0260);
        wr(10'd0, 32'hFFFF_FFF3);
        rd("R2 R3 keyed write", 10'd0, 32'h0000_0261);

        // R4 remap layout
        wr(10'd1, 32'hFFFF_FFFF);
        rd("R4 remap readback", 10'd1, 32'h3FFF_FFE0);
        wr(10'd1, 32'h0000_1000);
        rd("R4 remap base", 10'd1, 32'h2000_1000);

        // R5 comparator layout
        wr(10'd2, 32'hFFFF_FFFF);
        rd("R5 cmp readback", 10'd2, 32'hDFFF_FFFD);

        // R8 remap of instruction comparator 0
        wr(10'd2, 32'h0000_0101);
        acc("R8 remap idx0", 32'h0000_0100, 0, 1);
        chk("R8 remap value", {32'b0, out_addr}, {32'b0, 32'h2000_1000});
        acc("R7 literal ignores code cmp", 32'h0000_0100, 1, 1);

        // R10 literal comparator with non-00 action
        wr(10'd8, 32'hC000_0201);
        acc("R10 literal remaps", 32'h0000_0202, 1, 1);
        chk("R8 R10 literal remap value", {32'b0, out_addr}, {32'b0, 32'h2000_101A});
        acc("R7 fetch ignores literal cmp", 32'h0000_0200, 0, 1);

        // R11 priority, R9 breakpoint actions
        wr(10'd3, 32'h4000_0101);
        acc("R11 lowest wins", 32'h0000_0100, 0, 1);
        wr(10'd2, 32'h0000_0100);
        acc("R9 bkpt lo", 32'h0000_0100, 0, 1);
        chk("R9 bkpt lo flags", {61'b0, out_remap, out_bkpt_lo, out_bkpt_hi}, 64'b010);
        wr(10'd3, 32'h8000_0101);
        acc("R9 bkpt hi", 32'h0000_0100, 0, 1);
        wr(10'd3, 32'hC000_0101);
        acc("R9 bkpt both", 32'h0000_0100, 0, 1);
        chk("R9 addr unchanged", {32'b0, out_addr}, {32'b0, 32'h0000_0100});

        // R6 qualifiers
        acc("R6 outside code region", 32'h2000_0100, 0, 1);
        acc("R6 strobe low", 32'h0000_0100, 0, 0);
        wr(10'd0, 32'h0000_0002);
        acc("R6 global disable", 32'h0000_0100, 0, 1);
        wr(10'd0, 32'h0000_0003);

        // R13 write visible only after the capturing edge
        @(negedge clk);
        reg_wen = 1; reg_addr = 10'd4; reg_wdata = 32'h0000_0301;
        acc_valid = 1; acc_addr = 32'h0000_0300; acc_is_lit = 0;
        #1;
        chk("R13 same cycle old value", {61'b0, out_remap, out_bkpt_lo, out_bkpt_hi}, 64'b000);
        @(negedge clk);
        reg_wen = 0;
        model_wr(10'd4, 32'h0000_0301);
        #1;
        chk("R13 next cycle new value", {29'b0, out_remap, out_bkpt_lo, out_bkpt_hi, out_addr},
            {29'b0, 3'b100, 32'h2000_1008});

        // R12 identification words
        for (int k = 0; k < 12; k++) rd("R12 id word", 10'(10'h3F4 + k), id_exp(k));
        rd("R12 unmapped", 10'h200, 32'h0);

        // random mix, fixed seed
        void'($urandom(32'd1234));
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom % 4;
            if (sel == 0) begin
                int r = $urandom % 10;
                logic [31:0] d = $urandom;
                if (r >= 2) d[28:2] = pool[$urandom % 4];
                if (r == 0) d[1] = ($urandom % 4) != 0;
                wr(10'(r), d);
            end else begin
                logic [31:0] a = {3'b000, pool[$urandom % 4], 2'(($urandom % 4))};
                logic lit = $urandom % 2;
                if ($urandom % 10 == 0) a[31:29] = 3'($urandom);
                acc("R6 R7 R8 R9 R10 R11 random access", a, lit, ($urandom % 8) != 0);
            end
        end
        e = '0;
        acc("R6 final idle", 32'h0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule